// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This unit turns one IEEE-754 operand, either binary64 or binary32, into a 32-bit or 64-bit integer that is signed or unsigned. Each conversion also reports two exception flags, invalid and inexact. A single-precision operand is first widened exactly to double precision, so every later stage works on one format only. The unit handles special values and rounding directly. It rounds magnitudes below one half, saturates results that fall out of range, and corrects the flags when it saturates.

A request is offered by raising `in_valid` together with the operand and the three selects for precision, destination width and signedness, plus a 2-bit rounding mode. The result and both flags come back exactly one clock later with `out_valid`, so a new request can be accepted on every cycle. A signed conversion works on the absolute value of the operand. It remembers whether the result will be negated, so that directed rounding still acts on the true signed value, and it applies the sign as the last step.

Top module: `fp2i_convert`

## Requirements
- R1: With `is_single` high, only `operand[31:0]` is used, and it is read as binary32. Bit 31 is the sign, bits 30:23 the exponent and bits 22:0 the fraction. The converted value is the same as for the exactly equal binary64 value, and `operand[63:32]` has no effect. With `is_single` low, the bit layout is 63 sign, 62:52 exponent, 51:0 fraction.
- R2: A NaN of any kind raises invalid without inexact. The result is all ones in the destination width, which is -1 for signed destinations.
- R3: For an unsigned destination, +infinity returns the maximum of the width and -infinity returns 0. For a signed destination, +infinity returns the most positive value and -infinity the most negative value. Every infinity raises invalid without inexact.
- R4: +0 and -0 both return 0 and raise no flag.
- R5: A nonzero negative non-NaN operand with an unsigned destination returns 0 and raises invalid without inexact, even when its magnitude is below one half.
- R6: A nonzero magnitude below 0.5, denormals included, always raises inexact and gives a magnitude of 0 or 1. Encoding: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity. The magnitude is 1 only in mode 10 when the result will be negated, or in mode 11 when it will not be negated.
- R7: A magnitude of 0.5 or more is rounded in the selected mode. When the result will be negated, modes 10 and 11 trade places for the magnitude. Nearest-even sends ties to the even integer. Inexact is raised exactly when nonzero fraction bits are discarded.
- R8: For a signed destination, a rounded magnitude that is larger than 2^(W-1)-1 for a positive operand, or larger than 2^(W-1) for a negative one, saturates to that bound with the operand's sign. It then raises invalid and clears inexact. W is 32 or 64.
- R9: For an unsigned destination, a rounded magnitude that is larger than 2^W-1 returns 2^W-1. It raises invalid and clears inexact.
- R10: The result appears one cycle after `in_valid`, with `out_valid` high for exactly that cycle. A 32-bit result sits in `result[31:0]` with `result[63:32]` zero. Reset clears `out_valid`, `result` and both flags.
- R11: Invalid and inexact are never reported together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| in_valid | input | 1 | Request strobe |
| operand | input | 64 | Floating-point input (binary32 in the low half when single) |
| is_single | input | 1 | 1 selects binary32 input, 0 binary64 |
| dst_is64 | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| dst_signed | input | 1 | 1 selects a signed destination |
| round_mode | input | 2 | 00 nearest-even, 01 to zero, 10 down, 11 up |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Integer result, zero-extended when 32-bit |
| flag_invalid | output | 1 | Invalid exception for this result |
| flag_inexact | output | 1 | Inexact exception for this result |

## Verification
Rounding and saturation can both act on a single conversion. A value just under a bound can round up past it, and the saturation stage must then throw away the inexact flag that rounding has just raised. The bench provokes this with 2147483647.5 and with the neighbours of 2^32-1, 2^63 and 2^64, run through every rounding mode and every destination form. A second overlap is the negation flag: it mirrors the directed rounding modes and also chooses the saturation bound. Negative ties and negative values just beyond -2^31 are aimed at that overlap. Each result, and both flags, is judged against a reference in the bench. The reference splits the value into integer part and remainder with a different method from the one the design uses.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

  localparam int DP_W      = 64;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int DP_BIAS   = 1023;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;
  localparam int MANT_W    = DP_FRAC_W + 1;
  localparam int FRAC_GAP  = DP_FRAC_W - SP_FRAC_W;
  // binary64 biased exponent of the smallest binary32 denormal's leading bit position 0
  localparam int SP_DENORM_BASE = DP_BIAS - SP_BIAS - SP_FRAC_W + 1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_DOWN      = 2'b10,
    RM_UP        = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                sign;
    logic                is_nan;
    logic                is_inf;
    logic                is_zero;
    logic [DP_EXP_W-1:0] exp;
    logic [MANT_W-1:0]   mant;
  } fp_class_t;

  // Exact binary32 -> binary64 widening, denormals normalised.
  function automatic logic [DP_W-1:0] widen_single(input logic [SP_W-1:0] f);
    logic                 s;
    logic [SP_EXP_W-1:0]  e;
    logic [SP_FRAC_W-1:0] m;
    logic [DP_EXP_W-1:0]  de;
    logic [DP_FRAC_W-1:0] dm;
    int                   lead;
    s    = f[SP_W-1];
    e    = f[SP_W-2:SP_FRAC_W];
    m    = f[SP_FRAC_W-1:0];
    de   = '0;
    dm   = '0;
    lead = 0;
    if (e == '1) begin
      de = '1;
      dm = {m, {FRAC_GAP{1'b0}}};
    end else if (e == '0 && m == '0) begin
      de = '0;
      dm = '0;
    end else if (e == '0) begin
      for (int i = 0; i < SP_FRAC_W; i++) begin
        if (m[i]) lead = i;
      end
      de = DP_EXP_W'(lead + SP_DENORM_BASE);
      dm = DP_FRAC_W'({m, {FRAC_GAP{1'b0}}} << (SP_FRAC_W - lead));
    end else begin
      de = DP_EXP_W'({{(DP_EXP_W-SP_EXP_W){1'b0}}, e}) + DP_EXP_W'(DP_BIAS - SP_BIAS);
      dm = {m, {FRAC_GAP{1'b0}}};
    end
    return {s, de, dm};
  endfunction

  function automatic fp_class_t classify(input logic [DP_W-1:0] d);
    fp_class_t c;
    logic [DP_EXP_W-1:0]  e;
    logic [DP_FRAC_W-1:0] m;
    e         = d[DP_W-2:DP_FRAC_W];
    m         = d[DP_FRAC_W-1:0];
    c.sign    = d[DP_W-1];
    c.is_nan  = (e == '1) && (m != '0);
    c.is_inf  = (e == '1) && (m == '0);
    c.is_zero = (e == '0) && (m == '0);
    c.exp     = e;
    c.mant    = {(e != '0), m};
    return c;
  endfunction

  // Decide whether the kept magnitude steps up by one.
  // Directed modes are mirrored when the magnitude will later be negated.
  function automatic logic round_step(input rmode_e rm, input logic negate,
                                      input logic lsb, input logic rbit,
                                      input logic sticky);
    rmode_e eff;
    logic   step;
    eff = rm;
    if (negate && rm == RM_DOWN) eff = RM_UP;
    if (negate && rm == RM_UP)   eff = RM_DOWN;
    case (eff)
      RM_NEAR_EVEN: step = rbit & (sticky | lsb);
      RM_UP:        step = rbit | sticky;
      default:      step = 1'b0;
    endcase
    return step;
  endfunction

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
  import fp2i_pkg::*;
(
  input  logic [DP_W-1:0] operand,
  input  logic            is_single,
  output fp_class_t       cls
);
  logic [DP_W-1:0] wide;

  always_comb begin
    wide = is_single ? widen_single(operand[SP_W-1:0]) : operand;
    cls  = classify(wide);
  end
endmodule

// File: rtl/fp2i_magnitude.sv
module fp2i_magnitude
  import fp2i_pkg::*;
#(
  parameter int OUT_W = 64
) (
  input  fp_class_t        cls,
  input  rmode_e           rmode,
  input  logic             will_negate,
  output logic [OUT_W-1:0] mag,
  output logic             huge,
  output logic             inexact,
  output logic             tiny
);
  localparam int FIX_W    = MANT_W + OUT_W;
  localparam int SH_W     = $clog2(FIX_W + 1);
  localparam int HALF_EXP = DP_BIAS - 1;
  localparam int INT_EXP  = DP_BIAS + DP_FRAC_W;
  localparam int MAX_LSH  = OUT_W - MANT_W;

  logic             ordinary;
  int unsigned      ex;
  logic [FIX_W-1:0] fix;
  logic [MANT_W-1:0] ipart;
  logic [OUT_W-1:0] fpart;
  logic [SH_W-1:0]  rsh;
  int unsigned      lsh;
  logic             rbit;
  logic             sticky;

  always_comb begin
    ordinary = !cls.is_nan && !cls.is_inf && !cls.is_zero;
    ex       = {{(32-DP_EXP_W){1'b0}}, cls.exp};
    mag      = '0;
    huge     = 1'b0;
    inexact  = 1'b0;
    tiny     = 1'b0;
    fix      = '0;
    ipart    = '0;
    fpart    = '0;
    rsh      = '0;
    lsh      = 0;
    rbit     = 1'b0;
    sticky   = 1'b0;
    if (!ordinary) begin
      huge = cls.is_inf;
    end else if (ex < HALF_EXP) begin
      tiny    = 1'b1;
      inexact = 1'b1;
      mag     = {{(OUT_W-1){1'b0}}, round_step(rmode, will_negate, 1'b0, 1'b0, 1'b1)};
    end else if (ex >= INT_EXP) begin
      lsh = ex - INT_EXP;
      if (lsh > MAX_LSH) huge = 1'b1;
      else               mag  = OUT_W'(cls.mant) << lsh;
    end else begin
      rsh     = SH_W'(INT_EXP - ex);
      fix     = {cls.mant, {OUT_W{1'b0}}} >> rsh;
      ipart   = fix[FIX_W-1:OUT_W];
      fpart   = fix[OUT_W-1:0];
      rbit    = fpart[OUT_W-1];
      sticky  = |fpart[OUT_W-2:0];
      inexact = rbit | sticky;
      mag     = OUT_W'(ipart) + OUT_W'(round_step(rmode, will_negate, ipart[0], rbit, sticky));
    end
  end
endmodule

// File: rtl/fp2i_limit.sv
module fp2i_limit
  import fp2i_pkg::*;
#(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  fp_class_t        cls,
  input  logic [OUT_W-1:0] mag,
  input  logic             huge,
  input  logic             mag_inexact,
  input  logic             dst_is64,
  input  logic             dst_signed,
  output logic [OUT_W-1:0] value,
  output logic             invalid,
  output logic             inexact,
  output logic             nan_hit,
  output logic             neg_unsigned_hit,
  output logic             zero_hit,
  output logic             sat_hit
);
  localparam logic [OUT_W-1:0] U_WIDE   = '1;
  localparam logic [OUT_W-1:0] U_NARROW = {{(OUT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [OUT_W-1:0] S_WIDE   = U_WIDE >> 1;
  localparam logic [OUT_W-1:0] S_NARROW = U_NARROW >> 1;

  logic [OUT_W-1:0] lim;
  logic [OUT_W-1:0] kept;
  logic             negate;

  always_comb begin
    negate = dst_signed & cls.sign;
    if (dst_signed) lim = (dst_is64 ? S_WIDE : S_NARROW) + OUT_W'(cls.sign);
    else            lim = dst_is64 ? U_WIDE : U_NARROW;

    nan_hit          = cls.is_nan;
    neg_unsigned_hit = !dst_signed && cls.sign && !cls.is_nan && !cls.is_zero;
    zero_hit         = cls.is_zero;
    sat_hit          = !nan_hit && !neg_unsigned_hit && !zero_hit && (huge || mag > lim);

    invalid = 1'b0;
    inexact = 1'b0;
    kept    = '0;
    if (nan_hit) begin
      kept    = U_WIDE;
      invalid = 1'b1;
    end else if (neg_unsigned_hit || zero_hit) begin
      invalid = neg_unsigned_hit;
    end else if (sat_hit) begin
      kept    = negate ? (~lim + 1'b1) : lim;
      invalid = 1'b1;
    end else begin
      kept    = negate ? (~mag + 1'b1) : mag;
      inexact = mag_inexact;
    end
    value = dst_is64 ? kept : (kept & U_NARROW);
  end
endmodule

// File: rtl/fp2i_convert.sv
module fp2i_convert
  import fp2i_pkg::*;
#(
  parameter int OUT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DP_W-1:0]  operand,
  input  logic             is_single,
  input  logic             dst_is64,
  input  logic             dst_signed,
  input  logic [1:0]       round_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact
);
  fp_class_t        cls;
  logic             will_negate;
  logic [OUT_W-1:0] w_mag;
  logic             w_huge;
  logic             w_mag_inexact;
  logic             w_tiny_hit;
  logic [OUT_W-1:0] w_value;
  logic             w_invalid;
  logic             w_inexact;
  logic             w_nan_hit;
  logic             w_neg_unsigned_hit;
  logic             w_zero_hit;
  logic             w_sat_hit;

  assign will_negate = dst_signed & cls.sign;

  fp2i_unpack u_unpack (
    .operand  (operand),
    .is_single(is_single),
    .cls      (cls)
  );

  fp2i_magnitude #(.OUT_W(OUT_W)) u_magnitude (
    .cls        (cls),
    .rmode      (rmode_e'(round_mode)),
    .will_negate(will_negate),
    .mag        (w_mag),
    .huge       (w_huge),
    .inexact    (w_mag_inexact),
    .tiny       (w_tiny_hit)
  );

  fp2i_limit #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) u_limit (
    .cls             (cls),
    .mag             (w_mag),
    .huge            (w_huge),
    .mag_inexact     (w_mag_inexact),
    .dst_is64        (dst_is64),
    .dst_signed      (dst_signed),
    .value           (w_value),
    .invalid         (w_invalid),
    .inexact         (w_inexact),
    .nan_hit         (w_nan_hit),
    .neg_unsigned_hit(w_neg_unsigned_hit),
    .zero_hit        (w_zero_hit),
    .sat_hit         (w_sat_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= w_value;
        flag_invalid <= w_invalid;
        flag_inexact <= w_inexact;
      end
    end
  end
endmodule

// File: rtl/fp2i_convert_chk.sv
module fp2i_convert_chk #(
  parameter int OUT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             dst_is64,
  input logic             dst_signed,
  input logic             out_valid,
  input logic [OUT_W-1:0] result,
  input logic             flag_invalid,
  input logic             flag_inexact,
  input logic             nan_hit,
  input logic             neg_unsigned_hit,
  input logic             zero_hit,
  input logic             tiny_hit,
  input logic             sat_hit
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !dst_is64 |=> result[OUT_W-1:32] == '0);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(flag_invalid && flag_inexact));
  a_r2_nan_wide_ones: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_hit && dst_is64 |=> result == '1 && flag_invalid && !flag_inexact);
  a_r4_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && zero_hit |=> result == '0 && !flag_invalid && !flag_inexact);
  a_r5_neg_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && neg_unsigned_hit |=> result == '0 && flag_invalid && !flag_inexact);
  a_r6_tiny_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && tiny_hit && !neg_unsigned_hit |=> flag_inexact && !flag_invalid);
  a_r8_sat_flags: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_hit && dst_signed |=> flag_invalid && !flag_inexact);
  a_r9_sat_narrow_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_hit && !dst_signed && !dst_is64 |=>
      result == OUT_W'(64'hFFFF_FFFF) && flag_invalid && !flag_inexact);
endmodule

bind fp2i_convert fp2i_convert_chk #(.OUT_W(OUT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .dst_is64        (dst_is64),
  .dst_signed      (dst_signed),
  .out_valid       (out_valid),
  .result          (result),
  .flag_invalid    (flag_invalid),
  .flag_inexact    (flag_inexact),
  .nan_hit         (w_nan_hit),
  .neg_unsigned_hit(w_neg_unsigned_hit),
  .zero_hit        (w_zero_hit),
  .tiny_hit        (w_tiny_hit),
  .sat_hit         (w_sat_hit)
);

// File: tb/fp2i_convert_bench.sv
`timescale 1ns/1ps
module fp2i_convert_bench;

  typedef struct packed {
    logic [63:0] res;
    logic        inv;
    logic        inx;
  } ref_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic        is_single = 1'b0;
  logic        dst_is64 = 1'b0;
  logic        dst_signed = 1'b0;
  logic [1:0]  round_mode = 2'b00;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid;
  logic        flag_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp2i_convert u_fp2i_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .is_single(is_single), .dst_is64(dst_is64), .dst_signed(dst_signed),
    .round_mode(round_mode), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  // Reference: value = m * 2^(e - fw), split by integer division and remainder.
  function automatic ref_t ref_model(input logic [63:0] op, input logic sp,
                                     input logic w64, input logic sg,
                                     input logic [1:0] rm);
    ref_t r;
    logic neg, nan, inf, zero, inexact, up;
    logic [63:0] m, val, outv;
    logic [127:0] big, ip, rem, half, lim;
    logic [1:0] erm;
    int e, fw, k, n, be;
    r = '0; inexact = 1'b0; big = '0; m = '0;
    if (sp) begin
      neg = op[31]; be = int'(op[30:23]); fw = 23;
      nan = (be == 255) && (op[22:0] != 0);
      inf = (be == 255) && (op[22:0] == 0);
      zero = (be == 0) && (op[22:0] == 0);
      m = {41'b0, (be != 0), op[22:0]};
      e = (be == 0) ? -126 : be - 127;
    end else begin
      neg = op[63]; be = int'(op[62:52]); fw = 52;
      nan = (be == 2047) && (op[51:0] != 0);
      inf = (be == 2047) && (op[51:0] == 0);
      zero = (be == 0) && (op[51:0] == 0);
      m = {11'b0, (be != 0), op[51:0]};
      e = (be == 0) ? -1022 : be - 1023;
    end
    if (nan) begin
      r.res = w64 ? '1 : 64'hFFFF_FFFF; r.inv = 1'b1;
    end else if (zero) begin
      r.res = '0;
    end else if (!sg && neg) begin
      r.res = '0; r.inv = 1'b1;
    end else begin
      if (inf) big = '1;
      else begin
        k = e - fw;
        if (k >= 0) begin
          if (k > 64) big = '1; else big = {64'b0, m} << k;
        end else begin
          n = -k;
          if (n > 120) begin ip = '0; rem = 128'd1; half = 128'd1 << 119; end
          else begin
            ip = {64'b0, m} >> n;
            rem = {64'b0, m} - (ip << n);
            half = 128'd1 << (n - 1);
          end
          erm = rm;
          if (neg && rm == 2'b10) erm = 2'b11;
          if (neg && rm == 2'b11) erm = 2'b10;
          up = (rem != 0) && ((erm == 2'b00 && (rem > half || (rem == half && ip[0]))) || erm == 2'b11);
          inexact = (rem != 0);
          big = ip + {127'b0, up};
        end
      end
      if (sg) lim = (w64 ? (128'd1 << 63) : (128'd1 << 31)) - 128'd1 + {127'b0, neg};
      else    lim = (w64 ? (128'd1 << 64) : (128'd1 << 32)) - 128'd1;
      if (big > lim) begin val = lim[63:0]; r.inv = 1'b1; r.inx = 1'b0; end
      else begin val = big[63:0]; r.inx = inexact; end
      outv = (sg && neg) ? (64'd0 - val) : val;
      r.res = w64 ? outv : {32'b0, outv[31:0]};
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [63:0] op, input logic sp,
                                   input logic sg, input ref_t r);
    logic neg; int be; logic fz; string t;
    if (sp) begin neg = op[31]; be = int'(op[30:23]); fz = op[22:0] == 0; be = (be == 255) ? 2047 : be; end
    else begin neg = op[63]; be = int'(op[62:52]); fz = op[51:0] == 0; end
    if (be == 2047 && !fz)       t = "R2";
    else if (be == 2047)         t = "R3";
    else if (be == 0 && fz)      t = "R4";
    else if (!sg && neg)         t = "R5";
    else if (r.inv && sg)        t = "R8";
    else if (r.inv)              t = "R9";
    else if ((sp && be < 126) || (!sp && be < 1022)) t = "R6";
    else                         t = "R7";
    if (sp) t = {"R1/", t};
    return t;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, judge the registered output one cycle later.
  task automatic apply(input logic [63:0] op, input logic sp, input logic w64,
                       input logic sg, input logic [1:0] rm);
    ref_t r;
    string t;
    in_valid = 1'b1; operand = op; is_single = sp;
    dst_is64 = w64; dst_signed = sg; round_mode = rm;
    r = ref_model(op, sp, w64, sg, rm);
    t = tag_of(op, sp, sg, r);
    @(negedge clk);
    check(out_valid === 1'b1, "R10", "out_valid", {63'b0, out_valid}, 64'd1);
    check({result, flag_invalid, flag_inexact} === {r.res, r.inv, r.inx}, t,
          "result/inv/inx", result ^ {62'b0, flag_invalid, flag_inexact} ^ 64'd0,
          r.res);
    if ({result, flag_invalid, flag_inexact} !== {r.res, r.inv, r.inx})
      $display("     flags actual inv=%b inx=%b expected inv=%b inx=%b",
               flag_invalid, flag_inexact, r.inv, r.inx);
    check(!(flag_invalid && flag_inexact), "R11", "both flags",
          {62'b0, flag_invalid, flag_inexact}, 64'd0);
  endtask

  task automatic sweep(input logic [63:0] op, input logic sp);
    for (int c = 0; c < 16; c++) begin
      apply(op, sp, c[3], c[2], c[1:0]);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  logic [63:0] dvals [31] = '{
    64'h0000000000000000, 64'h8000000000000000, 64'h7FF0000000000000,
    64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001,
    64'hFFF8000000000000, 64'h3FE0000000000000, 64'hBFE0000000000000,
    64'h3FDFFFFFFFFFFFFF, 64'h3FF0000000000000, 64'hBFF0000000000000,
    64'h3FF8000000000000, 64'h4004000000000000, 64'hC004000000000000,
    64'h0000000000000001, 64'h8000000000000001, 64'h41DFFFFFFFC00000,
    64'h41E0000000000000, 64'hC1E0000000000000, 64'hC1E0000000200000,
    64'h41DFFFFFFFE00000, 64'hC1DFFFFFFFE00000, 64'h41EFFFFFFFE00000,
    64'h41F0000000000000, 64'h43E0000000000000, 64'hC3E0000000000000,
    64'h43DFFFFFFFFFFFFF, 64'h43F0000000000000, 64'h43EFFFFFFFFFFFFF,
    64'h7E37E43C8800759C
  };
  logic [31:0] svals [9] = '{
    32'h3F000000, 32'h7FC00000, 32'hFF800000, 32'h00000001, 32'h80000000,
    32'h4F000000, 32'hCF000000, 32'h3FC00000, 32'h4EFFFFFF
  };

  initial begin
    logic [63:0] op;
    logic sp;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid === 1'b0 && result === '0 && !flag_invalid && !flag_inexact,
          "R10", "reset state", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", "idle after reset", {63'b0, out_valid}, 64'd0);

    foreach (dvals[i]) sweep(dvals[i], 1'b0);
    // R1: single operands, upper half filled with junk that must not matter
    foreach (svals[i]) sweep({32'hDEADBEEF, svals[i]}, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      sp = ($urandom % 4) == 0;
      op = {$urandom, $urandom};
      if (($urandom % 16) != 0) begin
        if (sp) op[30:23] = 8'(124 + ($urandom % 70));
        else    op[62:52] = 11'(1020 + ($urandom % 70));
        if (($urandom % 3) == 0) begin
          if (sp) op[14:0] = '0; else op[31:0] = '0;
        end
      end
      apply(op, sp, 1'($urandom), 1'($urandom), 2'($urandom));
    end

    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", "strobe drops", {63'b0, out_valid}, 64'd0);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      report();
      $finish;
    end
  end

endmodule